// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a small processor with no general registers. Its working state is an internal operand stack. Each 32-bit instruction has an operation code in its upper byte and a 24-bit word address below it. Two instructions use that address. One loads a memory word onto the stack. The other takes the top value off the stack and stores it to memory. The arithmetic instructions take no operands: they fold the two topmost stack entries into one result.

Instructions and data share a single synchronous memory port. Read data returns one cycle after the address is presented. An instruction takes three cycles: fetch, decode and execute. A load from memory takes one more cycle. The core runs from word 0 after reset and stops for one of two reasons: it reaches the stop instruction, or it detects a fault. A fault is stack overflow, too few operands, a zero divisor or an unknown operation code. The fault cause is held on an output until the next reset. The top-of-stack value and the stack level are brought out so the surrounding system can observe the result.

Top module: `stkm_core`

## Requirements
- R1: Instruction bits [31:24] hold the operation code and bits [23:0] hold the word address. After reset, fetching starts at word 0 and moves up one word per completed instruction. Arithmetic instructions ignore the address field.
- R2: Operation 0x01 (load) reads the memory word at the instruction's address and places it on top of the stack, raising the level by one.
- R3: Operation 0x02 (store) writes the top value to the memory word at the instruction's address and removes that value from the stack.
- R4: Operation 0x10 replaces the two top entries with their sum, modulo 2^32.
- R5: Operation 0x11 replaces the two top entries with second minus top, so loading A, loading B, then subtracting gives A-B.
- R6: Operation 0x12 replaces the two top entries with the low 32 bits of their product.
- R7: Operation 0x13 replaces the two top entries with the unsigned quotient of second divided by top.
- R8: Operation 0x00 stops the core with err_cause 0. Once stopped, halted stays high and no memory write occurs until reset.
- R9: The stack holds 8 entries. Exactly 8 loads are accepted. A ninth load stops the core with err_cause 1 and leaves the stack unchanged.
- R10: A store on an empty stack, or an arithmetic operation with fewer than two entries, stops the core with err_cause 2 and leaves the stack unchanged.
- R11: Division by a zero top entry stops the core with err_cause 3 and leaves both operands in place.
- R12: Any operation code not listed above stops the core with err_cause 4.
- R13: While reset is asserted: halted is 0, err_cause is 0, stack_level is 0 and mem_we is 0.
- R14: The sequence load A, load B, multiply, load A, load C, load B, multiply, add, subtract leaves A*B-(A+C*B) as the only stack entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 24 | Word address of the memory port |
| mem_wdata | output | 32 | Write data for a store |
| mem_we | output | 1 | Write enable for the memory port |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| halted | output | 1 | Core has stopped |
| err_cause | output | 3 | 0 none, 1 overflow, 2 too few entries, 3 zero divisor, 4 unknown operation |
| stack_top | output | 32 | Value on top of the stack (0 when empty) |
| stack_level | output | 4 | Number of occupied stack entries |

## Verification
A store drives the memory write and shrinks the stack in the same cycle, and its write data must be the value that is being removed. The bench provokes this by storing each arithmetic result to a preset word and loading it back. It also empties a full stack one entry at a time into consecutive words, and judges the result by checking that the memory holds the values in reverse load order. A fault arrives in the same execute cycle in which a store or fold would otherwise have updated the stack. The bench provokes each fault at the exact boundary: the ninth load, a store on an empty stack, a fold with one entry, and a zero divisor. It then judges the stack_level, stack_top and preset memory words as unchanged.

// File: rtl/stkm_pkg.sv
package stkm_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_STOP = 8'h00;
   localparam logic [OPC_W-1:0] OPC_LOAD = 8'h01;
   localparam logic [OPC_W-1:0] OPC_STOR = 8'h02;
   localparam logic [OPC_W-1:0] OPC_ADD  = 8'h10;
   localparam logic [OPC_W-1:0] OPC_SUB  = 8'h11;
   localparam logic [OPC_W-1:0] OPC_MUL  = 8'h12;
   localparam logic [OPC_W-1:0] OPC_DIV  = 8'h13;

   typedef enum logic [1:0] {
      STK_HOLD,
      STK_PUSH,
      STK_POP,
      STK_FOLD
   } stk_op_e;

   typedef enum logic [1:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_MUL,
      ALU_DIV
   } alu_op_e;

   typedef enum logic [2:0] {
      FLT_NONE  = 3'd0,
      FLT_OVER  = 3'd1,
      FLT_UNDER = 3'd2,
      FLT_DIVZ  = 3'd3,
      FLT_BADOP = 3'd4
   } fault_e;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_EXEC,
      ST_LOAD,
      ST_STOP
   } state_e;

endpackage

// File: rtl/stkm_alu.sv
module stkm_alu
   import stkm_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   input  alu_op_e      sel,
   output logic [W-1:0] res,
   output logic         div_zero
);

   logic rhs_zero;
   assign rhs_zero = (rhs == '0);
   assign div_zero = (sel == ALU_DIV) && rhs_zero;

   always_comb begin
      case (sel)
         ALU_ADD: res = lhs + rhs;
         ALU_SUB: res = lhs - rhs;
         ALU_MUL: res = lhs * rhs;
         default: res = rhs_zero ? '0 : (lhs / rhs);
      endcase
   end

endmodule

// File: rtl/stkm_stack.sv
module stkm_stack
   import stkm_pkg::*;
#(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int LW   = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stk_op_e       op,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  top,
   output logic [W-1:0]  second,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);

   logic [LW-1:0]             lvl;
   logic [DEPTH-1:0][W-1:0]   cells;
   logic [IW-1:0]             top_idx;
   logic [IW-1:0]             sec_idx;

   initial begin
      assert (DEPTH >= 2) else $error("stack depth must hold two operands");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [W-1:0] q;
      logic         wr;
      assign wr = ((op == STK_PUSH) && (lvl == LW'(i))) ||
                  ((op == STK_FOLD) && (lvl == LW'(i + 2)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= '0;
         else if (wr) q <= din;
      end
      assign cells[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= '0;
      end else begin
         case (op)
            STK_PUSH: lvl <= lvl + LW'(1);
            STK_POP:  lvl <= lvl - LW'(1);
            STK_FOLD: lvl <= lvl - LW'(1);
            default:  lvl <= lvl;
         endcase
      end
   end

   assign top_idx = IW'(lvl - LW'(1));
   assign sec_idx = IW'(lvl - LW'(2));
   assign top     = (lvl == '0) ? '0 : cells[top_idx];
   assign second  = (lvl < LW'(2)) ? '0 : cells[sec_idx];
   assign level   = lvl;
   assign full    = (lvl == LW'(DEPTH));
   assign empty   = (lvl == '0);

   AST_LEVEL_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) lvl <= LW'(DEPTH)); // R9
   AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n) (op == STK_PUSH) |-> (lvl < LW'(DEPTH))); // R9
   AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (op == STK_POP) |-> (lvl != '0)); // R10
   AST_FOLD_HAS_TWO:  assert property (@(posedge clk) disable iff (!rst_n) (op == STK_FOLD) |-> (lvl >= LW'(2))); // R10

endmodule

// File: rtl/stkm_core.sv
module stkm_core
   import stkm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 24,
   parameter int DEPTH  = 8,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted,
   output logic [2:0]        err_cause,
   output logic [DATA_W-1:0] stack_top,
   output logic [LW-1:0]     stack_level
);

   initial begin
      assert (DATA_W == OPC_W + ADDR_W) else $error("instruction must fill one data word");
   end

   state_e            st, st_nxt;
   fault_e            flt, flt_nxt;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] ir;
   logic              pc_adv;
   stk_op_e           stk_op;
   logic [DATA_W-1:0] stk_din;
   logic [DATA_W-1:0] s_top, s_sec, alu_res;
   logic [LW-1:0]     s_lvl;
   logic              s_full, s_empty, alu_dz;
   alu_op_e           alu_sel;
   logic [OPC_W-1:0]  opc;
   logic [ADDR_W-1:0] opnd_addr;
   logic              is_arith;

   assign opc       = ir[DATA_W-1 -: OPC_W];
   assign opnd_addr = ir[ADDR_W-1:0];
   assign is_arith  = (opc == OPC_ADD) || (opc == OPC_SUB) ||
                      (opc == OPC_MUL) || (opc == OPC_DIV);

   always_comb begin
      case (opc)
         OPC_SUB: alu_sel = ALU_SUB;
         OPC_MUL: alu_sel = ALU_MUL;
         OPC_DIV: alu_sel = ALU_DIV;
         default: alu_sel = ALU_ADD;
      endcase
   end

   stkm_stack #(.W(DATA_W), .DEPTH(DEPTH)) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (stk_op),
      .din    (stk_din),
      .top    (s_top),
      .second (s_sec),
      .level  (s_lvl),
      .full   (s_full),
      .empty  (s_empty)
   );

   stkm_alu #(.W(DATA_W)) u_alu (
      .lhs      (s_sec),
      .rhs      (s_top),
      .sel      (alu_sel),
      .res      (alu_res),
      .div_zero (alu_dz)
   );

   always_comb begin
      st_nxt    = st;
      flt_nxt   = flt;
      mem_addr  = pc;
      mem_we    = 1'b0;
      mem_wdata = s_top;
      stk_op    = STK_HOLD;
      stk_din   = alu_res;
      pc_adv    = 1'b0;
      case (st)
         ST_FETCH:  st_nxt = ST_DECODE;
         ST_DECODE: st_nxt = ST_EXEC;
         ST_EXEC: begin
            if (opc == OPC_STOP) begin
               st_nxt = ST_STOP;
            end else if (opc == OPC_LOAD) begin
               if (s_full) begin
                  flt_nxt = FLT_OVER;
                  st_nxt  = ST_STOP;
               end else begin
                  mem_addr = opnd_addr;
                  st_nxt   = ST_LOAD;
               end
            end else if (opc == OPC_STOR) begin
               if (s_empty) begin
                  flt_nxt = FLT_UNDER;
                  st_nxt  = ST_STOP;
               end else begin
                  mem_addr = opnd_addr;
                  mem_we   = 1'b1;
                  stk_op   = STK_POP;
                  pc_adv   = 1'b1;
                  st_nxt   = ST_FETCH;
               end
            end else if (is_arith) begin
               if (s_lvl < LW'(2)) begin
                  flt_nxt = FLT_UNDER;
                  st_nxt  = ST_STOP;
               end else if (alu_dz) begin
                  flt_nxt = FLT_DIVZ;
                  st_nxt  = ST_STOP;
               end else begin
                  stk_op = STK_FOLD;
                  pc_adv = 1'b1;
                  st_nxt = ST_FETCH;
               end
            end else begin
               flt_nxt = FLT_BADOP;
               st_nxt  = ST_STOP;
            end
         end
         ST_LOAD: begin
            stk_op  = STK_PUSH;
            stk_din = mem_rdata;
            pc_adv  = 1'b1;
            st_nxt  = ST_FETCH;
         end
         default: st_nxt = ST_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_FETCH;
         flt <= FLT_NONE;
         pc  <= '0;
         ir  <= '0;
      end else begin
         st  <= st_nxt;
         flt <= flt_nxt;
         if (pc_adv)            pc <= pc + ADDR_W'(1);
         if (st == ST_DECODE)   ir <= mem_rdata;
      end
   end

   assign halted      = (st == ST_STOP);
   assign err_cause   = flt;
   assign stack_top   = s_top;
   assign stack_level = s_lvl;

   AST_STOP_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R8
   AST_STOP_NO_WRITE:   assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_we); // R8
   AST_FAULT_STOPS:     assert property (@(posedge clk) disable iff (!rst_n) (err_cause != 3'd0) |-> halted); // R12
   AST_FAULT_HELD:      assert property (@(posedge clk) disable iff (!rst_n) (err_cause != 3'd0) |=> $stable(err_cause)); // R12
   AST_STORE_SHRINKS:   assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> (stack_level == $past(stack_level) - LW'(1))); // R3
   AST_FAULT_KEEPS_STK: assert property (@(posedge clk) disable iff (!rst_n) $rose(halted) |-> $stable(stack_level)); // R10

endmodule

// File: tb/tb_stkm_core.sv
module tb_stkm_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_we;
   logic [31:0] mem_rdata;
   logic        halted;
   logic [2:0]  err_cause;
   logic [31:0] stack_top;
   logic [3:0]  stack_level;

   logic [31:0] mem [256];
   logic        ld_we = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;

   int vectors = 0;
   int misses  = 0;

   always #10 clk = ~clk;

   stkm_core dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
      .err_cause(err_cause), .stack_top(stack_top), .stack_level(stack_level)
   );

   always @(posedge clk) begin
      if (ld_we)       mem[ld_addr] <= ld_data;
      else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
   end

   function automatic logic [31:0] ins(input logic [7:0] op, input logic [23:0] a);
      return {op, a};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] a, input logic [31:0] d);
      ld_we = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic hold_reset();
      @(negedge clk);
      rst_n = 1'b0;
   endtask

   task automatic run_to_stop();
      int n;
      rst_n = 1'b1;
      n = 0;
      while (!halted && n < 4000) begin
         @(negedge clk);
         n++;
      end
      if (!halted) begin
         vectors++; misses++;
         $display("FAIL run timeout actual=running expected=halted");
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      vectors++; misses++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      logic [31:0] vals [12];
      logic [31:0] exp;
      vals[0] = 32'd0;          vals[1] = 32'd1;          vals[2] = 32'd2;
      vals[3] = 32'd3;          vals[4] = 32'd7;          vals[5] = 32'h7FFFFFFF;
      vals[6] = 32'h80000000;   vals[7] = 32'hFFFFFFFF;   vals[8] = 32'h12345678;
      vals[9] = 32'hDEADBEEF;   vals[10] = 32'd5;         vals[11] = 32'd100;

      // R13 reset state, then R1 first fetch at word 0
      hold_reset();
      put(8'h00, ins(8'h01, 24'h80));
      put(8'h01, ins(8'h02, 24'h90));
      put(8'h02, ins(8'h00, 24'h0));
      put(8'h80, 32'hCAFEF00D);
      put(8'h90, 32'h0);
      chk("R13 halted", {31'd0, halted}, 32'd0);
      chk("R13 err_cause", {29'd0, err_cause}, 32'd0);
      chk("R13 level", {28'd0, stack_level}, 32'd0);
      chk("R13 mem_we", {31'd0, mem_we}, 32'd0);
      rst_n = 1'b1;
      #1;
      chk("R1 first fetch address", {8'd0, mem_addr}, 32'd0);
      run_to_stop();
      chk("R2 R3 round trip", mem[8'h90], 32'hCAFEF00D);
      chk("R8 stop clean", {29'd0, err_cause}, 32'd0);

      // R4 R5 R6 R7 R11 sweep, address field of the fold set nonzero (R1)
      for (int oi = 0; oi < 4; oi++) begin
         for (int ai = 0; ai < 12; ai++) begin
            for (int bi = 0; bi < 12; bi++) begin
               hold_reset();
               put(8'h00, ins(8'h01, 24'h80));
               put(8'h01, ins(8'h01, 24'h81));
               put(8'h02, ins(8'h10 + 8'(oi), 24'h00ABCD));
               put(8'h03, ins(8'h02, 24'h82));
               put(8'h04, ins(8'h00, 24'h0));
               put(8'h80, vals[ai]);
               put(8'h81, vals[bi]);
               put(8'h82, 32'hA5A5A5A5);
               run_to_stop();
               case (oi)
                  0: exp = vals[ai] + vals[bi];
                  1: exp = vals[ai] - vals[bi];
                  2: exp = vals[ai] * vals[bi];
                  default: exp = (vals[bi] == 0) ? 32'h0 : vals[ai] / vals[bi];
               endcase
               if (oi == 3 && vals[bi] == 0) begin
                  chk("R11 cause", {29'd0, err_cause}, 32'd3);
                  chk("R11 level kept", {28'd0, stack_level}, 32'd2);
                  chk("R11 top kept", stack_top, vals[bi]);
                  chk("R11 no store", mem[8'h82], 32'hA5A5A5A5);
               end else begin
                  case (oi)
                     0: chk("R4 add", mem[8'h82], exp);
                     1: chk("R5 sub", mem[8'h82], exp);
                     2: chk("R6 mul", mem[8'h82], exp);
                     default: chk("R7 div", mem[8'h82], exp);
                  endcase
                  chk("R1 clean run", {25'd0, err_cause, stack_level}, 32'd0);
               end
            end
         end
      end

      // R9 full stack accepted, emptied in LIFO order (R2 R3)
      hold_reset();
      for (int k = 0; k < 8; k++) put(8'(k), ins(8'h01, 24'h80 + 24'(k)));
      for (int k = 0; k < 8; k++) put(8'(8 + k), ins(8'h02, 24'h90 + 24'(k)));
      put(8'd16, ins(8'h00, 24'h0));
      for (int k = 0; k < 8; k++) put(8'h80 + 8'(k), 32'h1000 + 32'(k * 3));
      run_to_stop();
      chk("R9 full accepted", {29'd0, err_cause}, 32'd0);
      for (int k = 0; k < 8; k++) chk("R3 LIFO order", mem[8'h90 + 8'(k)], 32'h1000 + 32'((7 - k) * 3));

      // R9 ninth load overflows
      hold_reset();
      for (int k = 0; k < 9; k++) put(8'(k), ins(8'h01, 24'h80 + 24'(k)));
      put(8'd9, ins(8'h00, 24'h0));
      run_to_stop();
      chk("R9 overflow cause", {29'd0, err_cause}, 32'd1);
      chk("R9 level kept", {28'd0, stack_level}, 32'd8);
      chk("R9 top kept", stack_top, 32'h1000 + 32'(7 * 3));

      // R10 store on empty
      hold_reset();
      put(8'h00, ins(8'h02, 24'h90));
      put(8'h90, 32'h5555AAAA);
      run_to_stop();
      chk("R10 empty store cause", {29'd0, err_cause}, 32'd2);
      chk("R10 no write", mem[8'h90], 32'h5555AAAA);

      // R10 fold with one entry
      hold_reset();
      put(8'h00, ins(8'h01, 24'h80));
      put(8'h01, ins(8'h12, 24'h0));
      put(8'h80, 32'h0000BEEF);
      run_to_stop();
      chk("R10 short fold cause", {29'd0, err_cause}, 32'd2);
      chk("R10 level kept", {28'd0, stack_level}, 32'd1);
      chk("R10 top kept", stack_top, 32'h0000BEEF);

      // R12 unknown codes
      for (int u = 0; u < 3; u++) begin
         hold_reset();
         put(8'h00, ins(8'h01, 24'h80));
         put(8'h01, ins((u == 0) ? 8'h14 : (u == 1) ? 8'h7F : 8'hFF, 24'h0));
         run_to_stop();
         chk("R12 bad code cause", {29'd0, err_cause}, 32'd4);
         chk("R12 level", {28'd0, stack_level}, 32'd1);
      end

      // R8 stop: later store never runs
      hold_reset();
      put(8'h00, ins(8'h01, 24'h80));
      put(8'h01, ins(8'h00, 24'h0));
      put(8'h02, ins(8'h02, 24'h90));
      put(8'h80, 32'h13579BDF);
      put(8'h90, 32'h2468ACE0);
      run_to_stop();
      repeat (20) @(negedge clk);
      chk("R8 still halted", {31'd0, halted}, 32'd1);
      chk("R8 cause none", {29'd0, err_cause}, 32'd0);
      chk("R8 no later store", mem[8'h90], 32'h2468ACE0);
      chk("R8 level", {28'd0, stack_level}, 32'd1);

      // R14 expression, two operand sets
      for (int e = 0; e < 2; e++) begin
         logic [31:0] a, b, c;
         a = (e == 0) ? 32'd6 : 32'd2;
         b = (e == 0) ? 32'd7 : 32'd3;
         c = (e == 0) ? 32'd3 : 32'd10;
         hold_reset();
         put(8'd0, ins(8'h01, 24'h80));
         put(8'd1, ins(8'h01, 24'h81));
         put(8'd2, ins(8'h12, 24'h0));
         put(8'd3, ins(8'h01, 24'h80));
         put(8'd4, ins(8'h01, 24'h82));
         put(8'd5, ins(8'h01, 24'h81));
         put(8'd6, ins(8'h12, 24'h0));
         put(8'd7, ins(8'h10, 24'h0));
         put(8'd8, ins(8'h11, 24'h0));
         put(8'd9, ins(8'h00, 24'h0));
         put(8'h80, a);
         put(8'h81, b);
         put(8'h82, c);
         run_to_stop();
         chk("R14 result", stack_top, a * b - (a + c * b));
         chk("R14 level", {28'd0, stack_level}, 32'd1);
         chk("R14 clean", {29'd0, err_cause}, 32'd0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule